// File: doc/BRIEF.md
# Biphase IR Frame Transmitter

This block turns a remote-control command into a light pattern on an infrared LED. When the transmitter is idle, a start request captures a 5-bit address and a 6-bit command. It then sends a frame of 32 half-bit slots of equal length. The frame opens with four dark slots. Next come two start bits, which are always one, and a toggle bit. The address follows with its most significant bit first, and the command comes last, also most significant bit first. Every bit takes two slots and is Manchester coded.

A slot that carries a one emits a burst of carrier pulses. A slot that carries a zero keeps the LED dark. The toggle bit inverts on every accepted frame, so a receiver can tell a repeated key press from a held key. The half-bit slot length, the carrier period and the number of pulses per burst are parameters counted in clock cycles.

Top module: `ir_tx`

## Requirements
- R1: After reset, `busy_o` and `led_o` are both low.
- R2: When `start_i` is high at a rising edge while `busy_o` is low, `busy_o` goes high in the next cycle. It stays high for exactly 32 × `TICK_CYCLES` cycles and then falls.
- R3: Slots 0 to 3 of a frame are dark. The 14 frame bits follow in this order: start one, start one, toggle, address[4] down to address[0], command[5] down to command[0]. Each bit occupies two consecutive slots, starting at slot 4.
- R4: A one is sent as a dark slot followed by a lit slot. A zero is sent as a lit slot followed by a dark slot.
- R5: The toggle state is 0 after reset. It inverts on each accepted start, and the frame carries the inverted value, so the first frame sends 1, the next sends 0, and so on.
- R6: A lit slot emits `PULSES` carrier periods of `CARRIER_CYCLES` cycles each, starting at the slot's first cycle. In each period `led_o` is high for the first `CARRIER_CYCLES`/2 cycles and low for the rest. `led_o` stays low for the remainder of the slot.
- R7: A dark slot keeps `led_o` low for all of its cycles.
- R8: A start request that arrives while `busy_o` is high is ignored. The frame in flight continues unchanged and no extra frame follows.
- R9: The address and command are captured in the cycle the start is accepted. Later changes to `addr_i` and `cmd_i` do not alter that frame.
- R10: `led_o` is low whenever `busy_o` is low.
- R11: A start held high across the end of a frame is accepted at the first rising edge at which `busy_o` is low. The next frame therefore begins one cycle after the previous one ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one frame |
| addr_i | input | 5 | Device address, captured on an accepted start |
| cmd_i | input | 6 | Command code, captured on an accepted start |
| busy_o | output | 1 | High while a frame is being sent |
| led_o | output | 1 | Modulated drive for the IR LED |

## Verification
An accepted start at edge E makes `busy_o` high from the cycle after E. From that cycle on, the LED level in cycle n depends only on slot n / `TICK_CYCLES` and on the offset n mod `TICK_CYCLES`. `busy_o` falls after cycle 32 × `TICK_CYCLES` − 1. The bench model counts n from its own record of accepted starts and predicts both outputs for every cycle. It compares them on the falling edge, half a cycle after the registers settle. This catches off-by-one errors at slot boundaries, at pulse boundaries and at the end of the frame.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  localparam int unsigned LEAD_SLOTS = 4;
  localparam int unsigned START_BITS = 2;

  // number of Manchester-coded bits in a frame
  function automatic int unsigned frame_bits(input int unsigned aw, input int unsigned cw);
    return START_BITS + 1 + aw + cw;
  endfunction

  function automatic int unsigned frame_slots(input int unsigned aw, input int unsigned cw);
    return LEAD_SLOTS + 2 * frame_bits(aw, cw);
  endfunction
endpackage

// File: rtl/ir_tx_frame_pack.sv
module ir_tx_frame_pack
  import ir_tx_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CMD_W  = 6,
  localparam int unsigned NBITS = frame_bits(ADDR_W, CMD_W),
  localparam int unsigned NSLOT = frame_slots(ADDR_W, CMD_W)
) (
  input  logic              toggle_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [NSLOT-1:0]  slots_o
);
  logic [NBITS-1:0] seq;

  assign seq[0] = 1'b1;
  assign seq[1] = 1'b1;
  assign seq[2] = toggle_i;

  for (genvar j = 0; j < ADDR_W; j++) begin : g_addr
    assign seq[3+j] = addr_i[ADDR_W-1-j];
  end
  for (genvar j = 0; j < CMD_W; j++) begin : g_cmd
    assign seq[3+ADDR_W+j] = cmd_i[CMD_W-1-j];
  end

  assign slots_o[LEAD_SLOTS-1:0] = '0;
  // Manchester coding: the first half is the inverse of the bit, the second half is the bit itself
  for (genvar i = 0; i < NBITS; i++) begin : g_man
    assign slots_o[LEAD_SLOTS+2*i]   = ~seq[i];
    assign slots_o[LEAD_SLOTS+2*i+1] =  seq[i];
  end
endmodule

// File: rtl/ir_tx_slot_timer.sv
module ir_tx_slot_timer #(
  parameter int unsigned TICK_CYCLES = 256,
  parameter int unsigned NSLOT       = 32,
  localparam int unsigned TW = $clog2(TICK_CYCLES),
  localparam int unsigned SW = $clog2(NSLOT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o,
  output logic slot_end_o
);
  logic [TW-1:0] tick_q;
  logic [SW-1:0] left_q;

  assign busy_o     = left_q != '0;
  assign slot_end_o = busy_o && (tick_q == TW'(TICK_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      tick_q <= '0;
      left_q <= SW'(NSLOT);
    end else if (slot_end_o) begin
      tick_q <= '0;
      left_q <= left_q - 1'b1;
    end else if (busy_o) begin
      tick_q <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/ir_tx_burst_gen.sv
module ir_tx_burst_gen #(
  parameter int unsigned CARRIER_CYCLES = 8,
  parameter int unsigned PULSES         = 30,
  localparam int unsigned PW   = $clog2(CARRIER_CYCLES),
  localparam int unsigned NW   = $clog2(PULSES + 1),
  localparam int unsigned HIGH = CARRIER_CYCLES / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic carrier_o
);
  logic [PW-1:0] phase_q;
  logic [NW-1:0] pulse_q;
  logic          burst_on;

  assign burst_on  = pulse_q < NW'(PULSES);
  assign carrier_o = burst_on && (phase_q < PW'(HIGH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pulse_q <= '0;
    end else if (restart_i) begin
      phase_q <= '0;
      pulse_q <= '0;
    end else if (phase_q == PW'(CARRIER_CYCLES - 1)) begin
      phase_q <= '0;
      if (burst_on) pulse_q <= pulse_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/ir_tx.sv
module ir_tx
  import ir_tx_pkg::*;
#(
  parameter int unsigned ADDR_W         = 5,
  parameter int unsigned CMD_W          = 6,
  parameter int unsigned TICK_CYCLES    = 256,
  parameter int unsigned CARRIER_CYCLES = 8,
  parameter int unsigned PULSES         = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              busy_o,
  output logic              led_o
);
  localparam int unsigned NSLOT = frame_slots(ADDR_W, CMD_W);

  logic             load;
  logic             slot_end;
  logic             carrier;
  logic             toggle_q;
  logic [NSLOT-1:0] frame;
  logic [NSLOT-1:0] shreg_q;

  assign load = start_i && !busy_o;

  ir_tx_frame_pack #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_pack (
    .toggle_i(~toggle_q),
    .addr_i  (addr_i),
    .cmd_i   (cmd_i),
    .slots_o (frame)
  );

  ir_tx_slot_timer #(.TICK_CYCLES(TICK_CYCLES), .NSLOT(NSLOT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .busy_o    (busy_o),
    .slot_end_o(slot_end)
  );

  ir_tx_burst_gen #(.CARRIER_CYCLES(CARRIER_CYCLES), .PULSES(PULSES)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(load || slot_end),
    .carrier_o(carrier)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      toggle_q <= 1'b0;
      shreg_q  <= '0;
    end else if (load) begin
      toggle_q <= ~toggle_q;
      shreg_q  <= frame;
    end else if (slot_end) begin
      shreg_q  <= shreg_q >> 1;
    end
  end

  assign led_o = busy_o && shreg_q[0] && carrier;
endmodule

// File: rtl/ir_tx_chk.sv
module ir_tx_chk #(
  parameter int unsigned TICK_CYCLES    = 256,
  parameter int unsigned CARRIER_CYCLES = 8,
  parameter int unsigned NSLOT          = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic led_o
);
  localparam int unsigned TOTAL = NSLOT * TICK_CYCLES;
  localparam int unsigned HIGH  = CARRIER_CYCLES / 2;

  int unsigned busy_run;
  int unsigned hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_run <= 0;
      hi_run   <= 0;
    end else begin
      busy_run <= busy_o ? busy_run + 1 : 0;
      hi_run   <= led_o ? hi_run + 1 : 0;
    end
  end

  assert_led_only_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o |-> busy_o);
  assert_busy_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_busy_needs_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_frame_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_run < TOTAL));
  assert_pulse_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o |-> (hi_run < HIGH));
endmodule

bind ir_tx ir_tx_chk #(
  .TICK_CYCLES   (TICK_CYCLES),
  .CARRIER_CYCLES(CARRIER_CYCLES),
  .NSLOT         (NSLOT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .led_o  (led_o)
);

// File: tb/ir_tx_bench.sv
`timescale 1ns/1ps
module ir_tx_bench;
  localparam int TICK  = 256;
  localparam int CARR  = 8;
  localparam int NPUL  = 30;
  localparam int NSLOT = 32;
  localparam int TOTAL = NSLOT * TICK;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] addr = '0;
  logic [5:0] cmd = '0;
  logic       busy, led;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  bit m_busy = 0;
  int m_n = 0;
  bit m_tog = 0;
  bit m_slots[NSLOT];

  always #2.5 clk = ~clk;

  ir_tx #(.TICK_CYCLES(TICK), .CARRIER_CYCLES(CARR), .PULSES(NPUL)) u_ir_tx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .cmd_i(cmd),
    .busy_o(busy), .led_o(led)
  );

  task automatic build_frame(input bit tg, input logic [4:0] a, input logic [5:0] c);
    bit q[$];
    bit bits[$];
    bits.push_back(1); bits.push_back(1); bits.push_back(tg);
    for (int i = 4; i >= 0; i--) bits.push_back(a[i]);
    for (int i = 5; i >= 0; i--) bits.push_back(c[i]);
    for (int i = 0; i < 4; i++) q.push_back(0);
    foreach (bits[k]) begin
      q.push_back(!bits[k]);
      q.push_back(bits[k]);
    end
    for (int i = 0; i < NSLOT; i++) m_slots[i] = q[i];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_n = 0; m_tog = 0;
    end else if (m_busy) begin
      if (m_n == TOTAL - 1) m_busy = 0;
      else m_n++;
    end else if (start) begin
      m_tog = !m_tog;
      build_frame(m_tog, addr, cmd);
      m_busy = 1;
      m_n = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int slot = m_n / TICK;
      automatic int off  = m_n % TICK;
      automatic bit e_led = m_busy && m_slots[slot] && (off < NPUL * CARR) && ((off % CARR) < CARR / 2);
      automatic string req;
      checks++;
      if (busy !== m_busy) begin
        errors++;
        $display("FAIL %s R2 busy n=%0d actual %b expected %b", tag, m_n, busy, m_busy);
      end
      checks++;
      if (!m_busy) req = "R10";
      else if (slot < 4) req = "R3";
      else if (m_slots[slot]) req = "R6";
      else req = "R7";
      if (led !== e_led) begin
        errors++;
        $display("FAIL %s %s led slot=%0d off=%0d actual %b expected %b", tag, req, slot, off, led, e_led);
      end
    end
  end

  task automatic send(input logic [4:0] a, input logic [5:0] c);
    @(negedge clk);
    addr = a; cmd = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during and right after reset
    checks++;
    if (busy !== 1'b0 || led !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual %b%b expected 00", busy, led);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    tag = "R4";               // alternating address and command bits, toggle=1
    send(5'h15, 6'h2A);
    wait_idle();

    tag = "R5";               // same data, toggle now 0
    send(5'h15, 6'h2A);
    wait_idle();

    tag = "R9";               // inputs change mid-frame; R8 start ignored while busy
    send(5'h1F, 6'h00);
    repeat (100) @(negedge clk);
    addr = 5'h00; cmd = 6'h3F;
    tag = "R8";
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3000) @(negedge clk);
    // R11: start held through the frame end restarts at once
    tag = "R11";
    addr = 5'h0A; cmd = 6'h15;
    start = 1'b1;
    while (m_busy) @(negedge clk);
    while (!m_busy) @(negedge clk);
    start = 1'b0;
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule